// File: doc/BRIEF.md
# Cache Portion Power Governor

This block decides how many power-gated portions of a shared last-level cache stay switched on. The cache sends it one pulse per hit and one pulse per miss. Two saturating counters accumulate these pulses over a fixed evaluation window. The window length is a cycle count, sized for a period of roughly 10 ms at the target clock. At each window boundary the counts are compared against energy break-even limits. The comparison can add one portion, remove one portion, or leave the count unchanged. The result is held in a target register that drives the cache's power control input.

The limits come from three programmed values. The first is a cost bandwidth CB, in events per window: the leakage of one portion divided by the DRAM energy per unit of data, precomputed off-block. The other two are an upsize threshold Tu and a downsize threshold Td. Both are unsigned fixed-point fractions with 8 fractional bits, so 256 means 1.00. A larger threshold biases the block toward keeping the cache big. Growth is judged on the miss count. Shrinking is judged on the hit count, scaled by the number of portions currently enabled (N).

A small state machine sequences each window. In `ST_PREP`, the first cycle of every window, the block registers the two limits for the coming window from the active configuration and from N. It then enters `ST_ACCUM` and stays there while events accumulate. On the window's last cycle it takes the decision, clears the counters and returns to `ST_PREP`. Configuration writes go to shadow registers, which are copied to the active set only at a window boundary.

Top module: `cache_portion_governor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `target_portions` equals MAX_PORTIONS and `eval_pulse` is 0.
- R2: `eval_pulse` is high for exactly one cycle, in the first cycle of each window. After the first window, consecutive pulses are exactly L cycles apart, where L is the window length active for that window.
- R3: The target grows by one when miss_count × 256 > (256 − Tu) × CB. The comparison is strict, so equality does not grow.
- R4: When R3's condition is false, the target shrinks by one when hit_count × 256 < (N × 256 − Td) × CB. The comparison is strict, so equality does not shrink.
- R5: In a window where R3's condition holds, the target never shrinks. This holds even when the target is already at MAX_PORTIONS.
- R6: The target changes by at most one per window and always stays between 1 and MAX_PORTIONS inclusive.
- R7: Each event counter saturates at 2^CNT_W − 1 instead of wrapping.
- R8: The counters restart at every boundary. A decision uses only the events of the cycles since the previous boundary.
- R9: A configuration write with `cfg_sel` = 0 sets the window length, 1 sets CB, 2 sets Tu and 3 sets Td. The new value takes effect from the next window boundary, not in the window where it is written.
- R10: Out-of-range configuration values are clamped. Tu or Td above 256 reads as 256. A window length below 2 reads as 2. A window length or CB above its field width saturates to all ones.
- R11: `target_portions` changes only in a cycle where `eval_pulse` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_evt | input | 1 | One cache hit in this cycle |
| miss_evt | input | 1 | One cache miss in this cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration field select (0 window, 1 cost, 2 up threshold, 3 down threshold) |
| cfg_wdata | input | 32 | Configuration write value |
| target_portions | output | $clog2(MAX_PORTIONS+1) | Number of cache portions to keep enabled |
| eval_pulse | output | 1 | High in the first cycle of each window; the new target is visible then |

## Verification
The bench builds the block with MAX_PORTIONS = 4, CNT_W = 8 and a 64-cycle default window. With only 4 portions, a short run can walk the target down to the floor of 1 and back up to the ceiling. The 8-bit counters saturate at 255, so a window of 300 events on a 400-cycle window separates saturation from wrap-around in the decision outcome. With the default CB of 16 and thresholds of 0.5, the limits land on small integers (8 misses, and 40 or 56 hits). This makes the strict-equality edges of both rules exact. The same setup also covers threshold clamping and the two-cycle minimum window.

// File: rtl/gov_pkg.sv
package gov_pkg;

    // Window sequencing states
    typedef enum logic [0:0] {
        ST_PREP  = 1'b0,   // first cycle of a window: limits are registered
        ST_ACCUM = 1'b1    // events accumulate until the window's last cycle
    } gov_state_e;

    // Configuration field selects
    localparam logic [1:0] SEL_WINDOW = 2'd0;
    localparam logic [1:0] SEL_COST   = 2'd1;
    localparam logic [1:0] SEL_UP     = 2'd2;
    localparam logic [1:0] SEL_DOWN   = 2'd3;

endpackage

// File: rtl/gov_event_counter.sv
module gov_event_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         evt,
    input  logic         clear,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (clear) begin
            // the event of the boundary cycle opens the next window
            count_q <= {{(W-1){1'b0}}, evt};
        end else if (evt && (count_q != ALL_ONES)) begin
            count_q <= count_q + W'(1);
        end
    end

    assign count = count_q;
endmodule

// File: rtl/gov_window_timer.sv
module gov_window_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] len,
    output logic         at_end
);
    logic [W-1:0] count_q;

    assign at_end = (count_q >= (len - W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (at_end) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + W'(1);
        end
    end
endmodule

// File: rtl/gov_limit_unit.sv
module gov_limit_unit #(
    parameter int CNT_W = 16,
    parameter int PW    = 4,
    parameter int FRAC  = 8,
    localparam int THR_W = FRAC + 1,
    localparam int SPAN_W = PW + FRAC + 1,
    localparam int LIM_W = CNT_W + PW + FRAC + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] cost,
    input  logic [THR_W-1:0] up_thr,
    input  logic [THR_W-1:0] dn_thr,
    input  logic [PW-1:0]    portions,
    output logic [LIM_W-1:0] up_lim,
    output logic [LIM_W-1:0] dn_lim
);
    localparam logic [THR_W-1:0] THR_ONE = {1'b1, {FRAC{1'b0}}};

    logic [THR_W-1:0]  up_span;
    logic [SPAN_W-1:0] dn_span;
    logic [LIM_W-1:0]  up_calc;
    logic [LIM_W-1:0]  dn_calc;

    always_comb begin
        up_span = THR_ONE - up_thr;
        dn_span = SPAN_W'({portions, {FRAC{1'b0}}}) - SPAN_W'(dn_thr);
        up_calc = LIM_W'(up_span) * LIM_W'(cost);
        dn_calc = LIM_W'(dn_span) * LIM_W'(cost);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            up_lim <= '0;
            dn_lim <= '0;
        end else if (load) begin
            up_lim <= up_calc;
            dn_lim <= dn_calc;
        end
    end
endmodule

// File: rtl/cache_portion_governor.sv
module cache_portion_governor
    import gov_pkg::*;
#(
    parameter int MAX_PORTIONS = 8,
    parameter int CNT_W        = 20,
    parameter int WIN_W        = 24,
    parameter int FRAC         = 8,
    parameter int WIN_DEFAULT  = 500000,
    parameter int COST_DEFAULT = 1000,
    parameter int UP_DEFAULT   = 128,
    parameter int DN_DEFAULT   = 128,
    localparam int PW          = $clog2(MAX_PORTIONS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit_evt,
    input  logic          miss_evt,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    output logic [PW-1:0] target_portions,
    output logic          eval_pulse
);
    localparam int THR_W = FRAC + 1;
    localparam int LIM_W = CNT_W + PW + FRAC + 1;
    localparam logic [THR_W-1:0] THR_ONE = {1'b1, {FRAC{1'b0}}};
    localparam logic [PW-1:0]    P_MAX   = PW'(MAX_PORTIONS);
    localparam logic [PW-1:0]    P_MIN   = PW'(1);

    // ------------------------------------------------------------------
    // Write-value clamping
    // ------------------------------------------------------------------
    function automatic logic [THR_W-1:0] clamp_thr(input logic [31:0] v);
        return (v > 32'(THR_ONE)) ? THR_ONE : v[THR_W-1:0];
    endfunction

    function automatic logic [WIN_W-1:0] clamp_win(input logic [31:0] v);
        if (v > 32'({WIN_W{1'b1}}))
            return {WIN_W{1'b1}};
        else if (v < 32'd2)
            return WIN_W'(2);
        else
            return v[WIN_W-1:0];
    endfunction

    function automatic logic [CNT_W-1:0] clamp_cost(input logic [31:0] v);
        if (v > 32'({CNT_W{1'b1}}))
            return {CNT_W{1'b1}};
        else
            return v[CNT_W-1:0];
    endfunction

    // ------------------------------------------------------------------
    // Shadow (written) and active (in use) configuration
    // ------------------------------------------------------------------
    logic [WIN_W-1:0] win_sh,  win_act;
    logic [CNT_W-1:0] cost_sh, cost_act;
    logic [THR_W-1:0] up_sh,   up_act;
    logic [THR_W-1:0] dn_sh,   dn_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_sh  <= clamp_win(32'(WIN_DEFAULT));
            cost_sh <= clamp_cost(32'(COST_DEFAULT));
            up_sh   <= clamp_thr(32'(UP_DEFAULT));
            dn_sh   <= clamp_thr(32'(DN_DEFAULT));
        end else if (cfg_we) begin
            unique case (cfg_sel)
                SEL_WINDOW: win_sh  <= clamp_win(cfg_wdata);
                SEL_COST:   cost_sh <= clamp_cost(cfg_wdata);
                SEL_UP:     up_sh   <= clamp_thr(cfg_wdata);
                SEL_DOWN:   dn_sh   <= clamp_thr(cfg_wdata);
                default:    ;
            endcase
        end
    end

    // ------------------------------------------------------------------
    // Window timer, event counters, limit precompute
    // ------------------------------------------------------------------
    gov_state_e state_q, state_d;
    logic       win_end;
    logic       boundary;
    logic [CNT_W-1:0] hit_cnt, miss_cnt;
    logic [LIM_W-1:0] up_lim, dn_lim;

    assign boundary = (state_q == ST_ACCUM) && win_end;

    gov_window_timer #(.W(WIN_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .len    (win_act),
        .at_end (win_end)
    );

    gov_event_counter #(.W(CNT_W)) u_hit_cnt (
        .clk   (clk),
        .rst   (rst),
        .evt   (hit_evt),
        .clear (boundary),
        .count (hit_cnt)
    );

    gov_event_counter #(.W(CNT_W)) u_miss_cnt (
        .clk   (clk),
        .rst   (rst),
        .evt   (miss_evt),
        .clear (boundary),
        .count (miss_cnt)
    );

    gov_limit_unit #(.CNT_W(CNT_W), .PW(PW), .FRAC(FRAC)) u_limits (
        .clk      (clk),
        .rst      (rst),
        .load     (state_q == ST_PREP),
        .cost     (cost_act),
        .up_thr   (up_act),
        .dn_thr   (dn_act),
        .portions (target_portions),
        .up_lim   (up_lim),
        .dn_lim   (dn_lim)
    );

    // ------------------------------------------------------------------
    // Decision
    // ------------------------------------------------------------------
    logic          grow_cond, shrink_cond;
    logic [PW-1:0] target_d;

    always_comb begin
        grow_cond   = ((LIM_W'(miss_cnt) << FRAC) > up_lim);
        shrink_cond = ((LIM_W'(hit_cnt)  << FRAC) < dn_lim);
        target_d    = target_portions;
        if (grow_cond) begin
            if (target_portions < P_MAX)
                target_d = target_portions + PW'(1);
        end else if (shrink_cond && (target_portions > P_MIN)) begin
            target_d = target_portions - PW'(1);
        end
    end

    // ------------------------------------------------------------------
    // State machine: state register and next state
    // ------------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_PREP;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PREP:  state_d = ST_ACCUM;
            ST_ACCUM: state_d = win_end ? ST_PREP : ST_ACCUM;
            default:  state_d = ST_PREP;
        endcase
    end

    // ------------------------------------------------------------------
    // Outputs and boundary-time updates
    // ------------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (rst) begin
            target_portions <= P_MAX;
            eval_pulse      <= 1'b0;
            win_act         <= clamp_win(32'(WIN_DEFAULT));
            cost_act        <= clamp_cost(32'(COST_DEFAULT));
            up_act          <= clamp_thr(32'(UP_DEFAULT));
            dn_act          <= clamp_thr(32'(DN_DEFAULT));
        end else begin
            eval_pulse <= boundary;
            if (boundary) begin
                target_portions <= target_d;
                win_act         <= win_sh;
                cost_act        <= cost_sh;
                up_act          <= up_sh;
                dn_act          <= dn_sh;
            end
        end
    end
endmodule

// File: rtl/gov_checker.sv
module gov_checker #(
    parameter int MAX_PORTIONS = 8,
    parameter int PW           = 4,
    parameter int CNT_W        = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             eval_pulse,
    input logic [PW-1:0]    target,
    input logic [CNT_W-1:0] hit_cnt,
    input logic [CNT_W-1:0] miss_cnt,
    input logic             boundary,
    input logic             grow_cond
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
    localparam logic [PW-1:0]    P_MAX    = PW'(MAX_PORTIONS);

    p_range_r6: assert property (@(posedge clk) disable iff (rst)
        (target >= PW'(1)) && (target <= P_MAX));

    p_step_r6: assert property (@(posedge clk) disable iff (rst)
        eval_pulse |-> ((target == $past(target)) ||
                        (target == $past(target) + PW'(1)) ||
                        (target + PW'(1) == $past(target))));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !eval_pulse |-> $stable(target));

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        eval_pulse |=> !eval_pulse);

    p_grow_r3: assert property (@(posedge clk) disable iff (rst)
        (eval_pulse && $past(grow_cond) && ($past(target) != P_MAX))
            |-> (target == $past(target) + PW'(1)));

    p_no_shrink_r5: assert property (@(posedge clk) disable iff (rst)
        (eval_pulse && $past(grow_cond)) |-> (target >= $past(target)));

    p_hit_sat_r7: assert property (@(posedge clk) disable iff (rst)
        (!boundary && (hit_cnt == ALL_ONES)) |=> (hit_cnt == ALL_ONES));

    p_miss_sat_r7: assert property (@(posedge clk) disable iff (rst)
        (!boundary && (miss_cnt == ALL_ONES)) |=> (miss_cnt == ALL_ONES));

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        boundary |=> ((hit_cnt <= CNT_W'(1)) && (miss_cnt <= CNT_W'(1))));
endmodule

bind cache_portion_governor gov_checker #(
    .MAX_PORTIONS (MAX_PORTIONS),
    .PW           (PW),
    .CNT_W        (CNT_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .eval_pulse (eval_pulse),
    .target     (target_portions),
    .hit_cnt    (hit_cnt),
    .miss_cnt   (miss_cnt),
    .boundary   (boundary),
    .grow_cond  (grow_cond)
);

// File: tb/cache_portion_governor_tb_top.sv
module cache_portion_governor_tb_top;
    localparam int MAXP    = 4;
    localparam int CW      = 8;
    localparam int WW      = 12;
    localparam int PW      = $clog2(MAXP + 1);
    localparam int CNT_MAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hit_evt = 1'b0;
    logic          miss_evt = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [31:0]   cfg_wdata = '0;
    logic [PW-1:0] target_portions;
    logic          eval_pulse;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_pulse = -1;
    bit done = 0;

    // model of configuration: shadow and active
    int sh_win = 64, sh_cost = 16, sh_up = 128, sh_dn = 128;
    int ac_win = 64, ac_cost = 16, ac_up = 128, ac_dn = 128;
    int exp_n  = MAXP;

    cache_portion_governor #(
        .MAX_PORTIONS (MAXP),
        .CNT_W        (CW),
        .WIN_W        (WW),
        .FRAC         (8),
        .WIN_DEFAULT  (64),
        .COST_DEFAULT (16),
        .UP_DEFAULT   (128),
        .DN_DEFAULT   (128)
    ) dut_i (
        .clk             (clk),
        .rst             (rst),
        .hit_evt         (hit_evt),
        .miss_evt        (miss_evt),
        .cfg_we          (cfg_we),
        .cfg_sel         (cfg_sel),
        .cfg_wdata       (cfg_wdata),
        .target_portions (target_portions),
        .eval_pulse      (eval_pulse)
    );

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_next(input int n, input int h, input int m);
        int hs, ms;
        bit grow, shrink;
        hs = (h > CNT_MAX) ? CNT_MAX : h;   // R7 saturation
        ms = (m > CNT_MAX) ? CNT_MAX : m;
        grow   = (ms * 256) > ((256 - ac_up) * ac_cost);
        shrink = (hs * 256) < ((n * 256 - ac_dn) * ac_cost);
        if (grow) return (n < MAXP) ? n + 1 : n;
        if (shrink && n > 1) return n - 1;
        return n;
    endfunction

    task automatic wr(input int sel, input int val);
        cfg_we    = 1'b1;
        cfg_sel   = 2'(sel);
        cfg_wdata = 32'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            0: sh_win  = (val > (1 << WW) - 1) ? (1 << WW) - 1 : ((val < 2) ? 2 : val);
            1: sh_cost = (val > CNT_MAX) ? CNT_MAX : val;
            2: sh_up   = (val > 256) ? 256 : val;
            default: sh_dn = (val > 256) ? 256 : val;
        endcase
    endtask

    // Drives h hits and m misses in consecutive cycles, then waits for the
    // next window start and checks the new target (R11: visible with pulse)
    // and the window period (R2).
    task automatic run_window(input string req, input int h, input int m);
        int n_cyc;
        int p;
        n_cyc = (h > m) ? h : m;
        for (int i = 0; i < n_cyc; i++) begin
            hit_evt  = (i < h);
            miss_evt = (i < m);
            @(negedge clk);
        end
        hit_evt  = 1'b0;
        miss_evt = 1'b0;
        while (eval_pulse !== 1'b1) @(negedge clk);
        exp_n = model_next(exp_n, h, m);
        check(req, int'(target_portions), exp_n);
        if (last_pulse >= 0) begin
            p = cyc - last_pulse;
            check("R2 period", p, ac_win);
        end
        last_pulse = cyc;
        ac_win = sh_win; ac_cost = sh_cost; ac_up = sh_up; ac_dn = sh_dn;
        @(negedge clk);
        check("R2 pulse width", int'(eval_pulse), 0);
    endtask

    // --- scenarios -----------------------------------------------------
    task automatic t_reset;
        check("R1 target", int'(target_portions), MAXP);
        check("R1 pulse", int'(eval_pulse), 0);
    endtask

    task automatic t_rules;
        run_window("R4 shrink on no hits", 0, 0);           // 4 -> 3
        run_window("R4 equality holds", 40, 0);             // limit 40, stays 3
        run_window("R5 grow beats shrink", 0, 9);           // 3 -> 4
        run_window("R5 at max no shrink", 0, 9);            // stays 4
        run_window("R3 equality no grow", 60, 8);           // stays 4
    endtask

    task automatic t_floor;
        run_window("R8 fresh window", 0, 0);                // 4 -> 3
        run_window("R6 step", 0, 0);                        // 2
        run_window("R6 step", 0, 0);                        // 1
        run_window("R6 floor", 0, 0);                       // stays 1
    endtask

    task automatic t_config;
        wr(1, 4); wr(2, 256); wr(3, 0);
        run_window("R9 deferred", 0, 1);                    // old cfg: stays 1
        run_window("R9 applied grow", 0, 1);                // 1 -> 2
        run_window("R4 equality new cfg", 8, 0);            // stays 2
        run_window("R4 shrink new cfg", 7, 0);              // 2 -> 1
    endtask

    task automatic t_saturate;
        wr(1, 200); wr(2, 0); wr(3, 32'h3FF); wr(0, 400);
        run_window("R9 cfg pending", 0, 0);                 // stays 1
        run_window("R7 miss saturation", 0, 300);           // 255>200: 1 -> 2
        run_window("R7 hit saturation", 300, 0);            // 255<200 false: stays 2
        run_window("R10 threshold clamp", 100, 0);          // 100<200: 2 -> 1
    endtask

    task automatic t_min_window;
        wr(0, 1);
        run_window("R10 window pending", 0, 0);
        run_window("R10 min window", 0, 0);
        run_window("R10 min window", 0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_rules();
        t_floor();
        t_config();
        t_saturate();
        t_min_window();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual=timeout expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule